// File: doc/BRIEF.md
# Iterative Integer Multiply and Divide Unit

This block performs 32-bit integer multiplication and division one bit per clock. A single start strobe launches one of four operations, selected by a two-bit code: signed multiply, unsigned multiply, signed divide or unsigned divide. The operands and the code are captured only on the start cycle. About one word-width of cycles later a one-cycle done pulse appears, together with the primary result, the secondary result and four condition flags: zero, sign, overflow and carry.

For a multiply, the primary result is the low half of the 64-bit product and the secondary result is the high half. For a divide, the primary result is the quotient and the secondary result is the remainder. Signed division truncates toward zero, and the remainder takes the sign of the dividend.

The flags follow fixed rules:
- The sign flag is always bit 31 of the primary result, even when the true product has the other sign.
- Overflow on a multiply means the high half carries information that the low half cannot hold.
- A zero divisor does not start an operation. It raises a divide-error pulse instead, and the previous results and flags stay as they were.

Top module: `iter_muldiv`

## Requirements
- R1: Operation code 0 is signed multiply. The primary result is bits 31:0 and the secondary result is bits 63:32 of the two's-complement product (-3 × 2 gives 0xFFFFFFFA and 0xFFFFFFFF).
- R2: Operation code 1 is unsigned multiply. The primary and secondary results are the low and high words of the unsigned 64-bit product (0xFFFFFFFF × 0xFFFFFFFF gives 0x00000001 and 0xFFFFFFFE).
- R3: After any multiply, the flags are set as follows:
  - zero is set when the primary result is 0;
  - sign equals bit 31 of the primary result;
  - carry is 0;
  - overflow is set for a signed multiply when the high word is not all copies of bit 31 of the low word, and for an unsigned multiply when the high word is nonzero.
- R4: Operation code 2 is signed divide. The quotient is truncated toward zero and the remainder has the dividend's sign (-9 / 2 gives -4 remainder -1; 9 / -2 gives -4 remainder 1).
- R5: Operation code 3 is unsigned divide, with both operands taken as unsigned (0xFFFFFFF7 / 2 gives 0x7FFFFFFB remainder 1).
- R6: After any divide, zero and sign reflect the quotient and carry is 0. Overflow is 0 except for the signed divide 0x80000000 / -1, which returns quotient 0x80000000, remainder 0 and sets overflow.
- R7: A divide with a zero divisor raises divErr for exactly the one cycle after the start edge, never produces done, and leaves both results and all four flags unchanged.
- R8: done is a single-cycle pulse visible exactly 33 clock edges after the start edge. busy is high from the edge after the start edge until done appears.
- R9: A start strobe while busy is high is ignored. The running operation completes with the operands captured at its own start.
- R10: After reset, both results, all flags, done, divErr and busy are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch strobe, sampled while idle |
| opSel | input | 2 | 0 signed mul, 1 unsigned mul, 2 signed div, 3 unsigned div |
| opA | input | 32 | Multiplicand or dividend |
| opB | input | 32 | Multiplier or divisor |
| resLo | output | 32 | Low product word or quotient |
| resHi | output | 32 | High product word or remainder |
| flagZ | output | 1 | Zero flag |
| flagS | output | 1 | Sign flag |
| flagV | output | 1 | Overflow flag |
| flagC | output | 1 | Carry flag |
| done | output | 1 | One-cycle result-valid pulse |
| divErr | output | 1 | One-cycle zero-divisor pulse |
| busy | output | 1 | Operation in progress |

## Verification
The assertions check on every cycle:
- done and divErr never rise together, and done never lasts more than one cycle;
- carry is clear at every done;
- zero and sign at every done are consistent with the primary result;
- results hold still across a divide-error pulse;
- a busy period never exceeds the cycle budget;
- an accepted start always raises busy.

Only the bench's scenarios can show the arithmetic itself: the product halves, the truncation and remainder signs, the overflow corner of the most negative dividend, the high-word overflow rule, the exact 33-cycle latency and the rejection of a start issued mid-operation.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  typedef enum logic [1:0] {
    OP_MULS = 2'd0,
    OP_MULU = 2'd1,
    OP_DIVS = 2'd2,
    OP_DIVU = 2'd3
  } mdu_op_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic step;
    logic finish;
  } mdu_strb_t;

  typedef struct packed {
    logic z;
    logic s;
    logic v;
    logic c;
  } mdu_flags_t;

endpackage

// File: rtl/mdu_ctrl.sv
module mdu_ctrl
  import mdu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      divByZero,
  output mdu_strb_t strb,
  output logic      done,
  output logic      divErr,
  output logic      busy
);

  localparam int CNT_W = $clog2(WIDTH);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} state_t;

  state_t          state;
  logic [CNT_W-1:0] stepCnt;
  logic            accept;

  assign accept      = (state == S_IDLE) && start && !divByZero;
  assign strb.load   = accept;
  assign strb.step   = (state == S_RUN);
  assign strb.finish = (state == S_FIN);
  assign busy        = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      stepCnt <= '0;
      done    <= 1'b0;
      divErr  <= 1'b0;
    end else begin
      done   <= strb.finish;
      divErr <= (state == S_IDLE) && start && divByZero;
      unique case (state)
        S_IDLE: begin
          stepCnt <= '0;
          if (accept) state <= S_RUN;
        end
        S_RUN: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == LAST_STEP) state <= S_FIN;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mdu_datapath.sv
module mdu_datapath
  import mdu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  mdu_strb_t        strb,
  input  logic [1:0]       opSel,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic             divByZero,
  output logic [WIDTH-1:0] resLo,
  output logic [WIDTH-1:0] resHi,
  output mdu_flags_t       flags
);

  localparam int W2 = 2 * WIDTH;
  localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

  mdu_op_t          opReg;
  logic             negA, negB, ovfCase;
  logic [WIDTH-1:0] opnd;
  logic [W2-1:0]    acc;

  // operand capture
  logic             inSigned, inNegA, inNegB;
  logic [WIDTH-1:0] magA, magB;

  assign divByZero = opSel[1] && (opB == '0);
  assign inSigned  = !opSel[0];
  assign inNegA    = inSigned && opA[WIDTH-1];
  assign inNegB    = inSigned && opB[WIDTH-1];
  assign magA      = inNegA ? (~opA + 1'b1) : opA;
  assign magB      = inNegB ? (~opB + 1'b1) : opB;

  // one radix-2 step of each algorithm
  logic [WIDTH:0]   mulSum;
  logic [WIDTH:0]   divShift, divDiff;
  logic             qBit;
  logic [W2-1:0]    mulNext, divNext;

  assign mulSum  = {1'b0, acc[W2-1:WIDTH]} + (acc[0] ? {1'b0, opnd} : '0);
  assign mulNext = {mulSum, acc[WIDTH-1:1]};

  assign divShift = {acc[W2-1:WIDTH], acc[WIDTH-1]};
  assign divDiff  = divShift - {1'b0, opnd};
  assign qBit     = !divDiff[WIDTH];
  assign divNext  = {(qBit ? divDiff[WIDTH-1:0] : divShift[WIDTH-1:0]),
                     acc[WIDTH-2:0], qBit};

  // sign fix-up and flags for the finish cycle
  logic             isDiv, isSignedOp;
  logic [W2-1:0]    prodFix;
  logic [WIDTH-1:0] quoFix, remFix, finLo, finHi;
  mdu_flags_t       finFlags;

  assign isDiv      = opReg[1];
  assign isSignedOp = !opReg[0];
  assign prodFix    = (negA ^ negB) ? (~acc + 1'b1) : acc;
  assign quoFix     = (negA ^ negB) ? (~acc[WIDTH-1:0] + 1'b1) : acc[WIDTH-1:0];
  assign remFix     = negA ? (~acc[W2-1:WIDTH] + 1'b1) : acc[W2-1:WIDTH];
  assign finLo      = isDiv ? quoFix : prodFix[WIDTH-1:0];
  assign finHi      = isDiv ? remFix : prodFix[W2-1:WIDTH];

  always_comb begin
    finFlags.z = (finLo == '0);
    finFlags.s = finLo[WIDTH-1];
    finFlags.c = 1'b0;
    if (isDiv)           finFlags.v = ovfCase;
    else if (isSignedOp) finFlags.v = (finHi != {WIDTH{finLo[WIDTH-1]}});
    else                 finFlags.v = (finHi != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opReg   <= OP_MULS;
      negA    <= 1'b0;
      negB    <= 1'b0;
      ovfCase <= 1'b0;
      opnd    <= '0;
      acc     <= '0;
      resLo   <= '0;
      resHi   <= '0;
      flags   <= '0;
    end else begin
      if (strb.load) begin
        opReg   <= mdu_op_t'(opSel);
        negA    <= inNegA;
        negB    <= inNegB;
        ovfCase <= (opSel == OP_DIVS) && (opA == MOST_NEG) && (&opB);
        opnd    <= magB;
        acc     <= {{WIDTH{1'b0}}, magA};
      end else if (strb.step) begin
        acc <= isDiv ? divNext : mulNext;
      end
      if (strb.finish) begin
        resLo <= finLo;
        resHi <= finHi;
        flags <= finFlags;
      end
    end
  end

endmodule

// File: rtl/iter_muldiv.sv
module iter_muldiv
  import mdu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [1:0]       opSel,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] resLo,
  output logic [WIDTH-1:0] resHi,
  output logic             flagZ,
  output logic             flagS,
  output logic             flagV,
  output logic             flagC,
  output logic             done,
  output logic             divErr,
  output logic             busy
);

  mdu_strb_t  strb;
  mdu_flags_t flags;
  logic       divByZero;

  mdu_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .divByZero (divByZero),
    .strb      (strb),
    .done      (done),
    .divErr    (divErr),
    .busy      (busy)
  );

  mdu_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .opSel     (opSel),
    .opA       (opA),
    .opB       (opB),
    .divByZero (divByZero),
    .resLo     (resLo),
    .resHi     (resHi),
    .flags     (flags)
  );

  assign flagZ = flags.z;
  assign flagS = flags.s;
  assign flagV = flags.v;
  assign flagC = flags.c;

endmodule

// File: rtl/iter_muldiv_checker.sv
module iter_muldiv_checker #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [1:0]       opSel,
  input logic [WIDTH-1:0] opB,
  input logic [WIDTH-1:0] resLo,
  input logic [WIDTH-1:0] resHi,
  input logic             flagZ,
  input logic             flagS,
  input logic             flagV,
  input logic             flagC,
  input logic             done,
  input logic             divErr,
  input logic             busy
);

  localparam int BUSY_MAX = WIDTH + 1;
  localparam int CNT_W = $clog2(BUSY_MAX + 2) + 1;

  logic [CNT_W-1:0] busyCnt;

  always_ff @(posedge clk) begin
    if (!rstN || !busy) busyCnt <= '0;
    else busyCnt <= busyCnt + 1'b1;
  end

  p_err_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(done && divErr));

  p_err_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    divErr |-> ($stable(resLo) && $stable(resHi) && $stable(flagV)));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_latency_r8: assert property (@(posedge clk) disable iff (!rstN)
    busyCnt <= CNT_W'(BUSY_MAX));

  p_carry_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !flagC);

  p_zero_sign_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ((flagZ == (resLo == '0)) && (flagS == resLo[WIDTH-1])));

  p_accept_r9: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && !(opSel[1] && opB == '0)) |=> busy);

endmodule

bind iter_muldiv iter_muldiv_checker #(.WIDTH(WIDTH)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .opSel  (opSel),
  .opB    (opB),
  .resLo  (resLo),
  .resHi  (resHi),
  .flagZ  (flagZ),
  .flagS  (flagS),
  .flagV  (flagV),
  .flagC  (flagC),
  .done   (done),
  .divErr (divErr),
  .busy   (busy)
);

// File: tb/iter_muldiv_bench.sv
module iter_muldiv_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  opSel = '0;
  logic [31:0] opA = '0, opB = '0;
  logic [31:0] resLo, resHi;
  logic        flagZ, flagS, flagV, flagC, done, divErr, busy;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  iter_muldiv u_iter_muldiv (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel), .opA(opA), .opB(opB),
    .resLo(resLo), .resHi(resHi), .flagZ(flagZ), .flagS(flagS), .flagV(flagV),
    .flagC(flagC), .done(done), .divErr(divErr), .busy(busy)
  );

  // {op, a, b, lo, hi, flags ZSVC}
  localparam int NVEC = 18;
  localparam logic [133:0] VECS [NVEC] = '{
    {2'd0, 32'h00000003, 32'h00000002, 32'h00000006, 32'h00000000, 4'b0000},
    {2'd0, 32'hFFFFFFFD, 32'h00000002, 32'hFFFFFFFA, 32'hFFFFFFFF, 4'b0100},
    {2'd0, 32'h0001E240, 32'h00015666, 32'h8501A580, 32'h00000002, 4'b0110},
    {2'd0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 4'b0000},
    {2'd0, 32'h00000009, 32'h00000000, 32'h00000000, 32'h00000000, 4'b1000},
    {2'd1, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000001, 32'hFFFFFFFE, 4'b0010},
    {2'd1, 32'hFFFFFFFD, 32'hFFFFFFFE, 32'h00000006, 32'hFFFFFFFB, 4'b0010},
    {2'd1, 32'h00000003, 32'hFFFFFFFE, 32'hFFFFFFFA, 32'h00000002, 4'b0110},
    {2'd2, 32'h00000009, 32'h00000002, 32'h00000004, 32'h00000001, 4'b0000},
    {2'd2, 32'hFFFFFFF7, 32'h00000002, 32'hFFFFFFFC, 32'hFFFFFFFF, 4'b0100},
    {2'd2, 32'h00000009, 32'hFFFFFFFE, 32'hFFFFFFFC, 32'h00000001, 4'b0100},
    {2'd2, 32'hFFFFFFF7, 32'hFFFFFFFE, 32'h00000004, 32'hFFFFFFFF, 4'b0000},
    {2'd2, 32'h00000009, 32'h0000000A, 32'h00000000, 32'h00000009, 4'b1000},
    {2'd2, 32'h80000000, 32'hFFFFFFFF, 32'h80000000, 32'h00000000, 4'b0110},
    {2'd3, 32'hFFFFFFF7, 32'h00000002, 32'h7FFFFFFB, 32'h00000001, 4'b0000},
    {2'd3, 32'h00000009, 32'hFFFFFFFE, 32'h00000000, 32'h00000009, 4'b1000},
    {2'd3, 32'hFFFFFFF7, 32'hFFFFFFFE, 32'h00000000, 32'hFFFFFFF7, 4'b1000},
    {2'd3, 32'h80000000, 32'hFFFFFFFF, 32'h00000000, 32'h80000000, 4'b1000}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // launch an op and wait for done; returns edges from start edge to done
  task automatic run_op(input logic [1:0] op, input logic [31:0] a,
                        input logic [31:0] b, output int lat);
    @(negedge clk);
    start = 1'b1; opSel = op; opA = a; opB = b;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    for (int i = 0; i < 60; i++) begin
      if (done) break;
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    #(20 * 20000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int lat;
    string rqRes, rqFlg;
    logic [31:0] keepLo, keepHi;
    logic [3:0]  keepF;

    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", "resLo", resLo, 32'h0);
    check("R10", "resHi", resHi, 32'h0);
    check("R10", "flags/done/err/busy", {25'd0, flagZ, flagS, flagV, flagC, done, divErr, busy}, 32'h0);
    rstN = 1'b1;

    for (int k = 0; k < NVEC; k++) begin
      logic [133:0] v;
      v = VECS[k];
      unique case (v[133:132])
        2'd0: begin rqRes = "R1"; rqFlg = "R3"; end
        2'd1: begin rqRes = "R2"; rqFlg = "R3"; end
        2'd2: begin rqRes = "R4"; rqFlg = "R6"; end
        default: begin rqRes = "R5"; rqFlg = "R6"; end
      endcase
      run_op(v[133:132], v[131:100], v[99:68], lat);
      check(rqRes, $sformatf("vec%0d lo", k), resLo, v[67:36]);
      check(rqRes, $sformatf("vec%0d hi", k), resHi, v[35:4]);
      check(rqFlg, $sformatf("vec%0d flags", k), {28'd0, flagZ, flagS, flagV, flagC}, {28'd0, v[3:0]});
      check("R8", $sformatf("vec%0d latency", k), lat, 33);
      @(negedge clk);
      check("R8", "done single pulse", {31'd0, done}, 32'h0);
    end

    // R7 zero divisor after a known result
    run_op(2'd1, 32'hFFFFFFFF, 32'hFFFFFFFF, lat);
    keepLo = resLo; keepHi = resHi; keepF = {flagZ, flagS, flagV, flagC};
    @(negedge clk);
    start = 1'b1; opSel = 2'd2; opA = 32'd5; opB = 32'd0;
    @(negedge clk);
    start = 1'b0;
    check("R7", "divErr pulse", {31'd0, divErr}, 32'h1);
    check("R7", "busy after zero divisor", {31'd0, busy}, 32'h0);
    @(negedge clk);
    check("R7", "divErr cleared", {31'd0, divErr}, 32'h0);
    for (int i = 0; i < 40; i++) begin
      if (done) begin
        check("R7", "done after zero divisor", 32'h1, 32'h0);
        break;
      end
      @(negedge clk);
    end
    check("R7", "resLo unchanged", resLo, keepLo);
    check("R7", "resHi unchanged", resHi, keepHi);
    check("R7", "flags unchanged", {28'd0, flagZ, flagS, flagV, flagC}, {28'd0, keepF});

    // R9 start while busy is ignored
    @(negedge clk);
    start = 1'b1; opSel = 2'd1; opA = 32'd3; opB = 32'd2;
    @(negedge clk);
    start = 1'b0;
    check("R8", "busy after start", {31'd0, busy}, 32'h1);
    repeat (5) @(negedge clk);
    start = 1'b1; opSel = 2'd3; opA = 32'd100; opB = 32'd7;
    @(negedge clk);
    start = 1'b0;
    lat = 6;
    for (int i = 0; i < 60; i++) begin
      if (done) break;
      @(negedge clk);
      lat++;
    end
    check("R9", "latency unaffected", lat, 33);
    check("R9", "lo from first op", resLo, 32'd6);
    check("R9", "hi from first op", resHi, 32'd0);
    @(negedge clk);
    check("R9", "no second done", {31'd0, busy | done}, 32'h0);

    finish_run();
  end

endmodule